// File: doc/BRIEF.md
# Single-Channel Word DMA Engine with Fill and Block Pacing

This block is one 32-bit DMA channel. Software programs seven word-wide registers and then sets the enable bit in the control word. The channel then moves 32-bit words over a simple memory request port that uses a valid/ready handshake. It reads each word from a source address and writes it to a destination address. In fill mode it skips the reads and writes the contents of the fill register into every destination word.

Each address can count up, count down or stay fixed. Words are grouped into blocks of 2^n words, and a programmable, prescaled idle gap separates one block from the next. A transfer runs at once, or it waits for one of sixteen trigger lines; a code in the control word selects the line. Each trigger moves a fixed number of words. A separate total count ends a triggered run. Optional reloads restore either working address after every triggered burst.

Software detects the end of a run by polling the enable bit, which clears by itself. A one-cycle interrupt pulse can also report it.

Top module: `wdma_chan`

## Requirements
- R1: After a synchronous reset, all seven registers read as zero, no request is valid and `irq` is low.
- R2: The registers sit at `reg_addr` 0 to 6: source address, destination address, total count, words per trigger, gap setting, fill word, control. A read returns the selected register one cycle after `reg_addr` is presented. Addresses 0 to 5 read back exactly what was written. Control reads back the written value, except that bit 31 shows whether the channel is running.
- R3: Writing control with bit 31 set while the channel is idle starts it. Bit 31 stays 1 while the channel is active and clears by itself when the run ends. While bit 31 is 1, writes to any register are ignored. No memory request is issued while bit 31 is 0.
- R4: Immediate mode (control bit 28 = 1) moves exactly the words-per-trigger count and then stops, unless the repeat bit is set.
- R5: The destination mode in control bits 11:10 selects 0 = step by +4 bytes per word, 1 = step by -4 bytes per word, 2 = fixed address.
- R6: The source mode in control bits 14:13 uses the same codes as R5. Code 3 selects fill mode: no read request is ever issued, and every written word equals the fill register.
- R7: Control bits 19:16 hold n, and a block is 2^n words. The gap register holds an idle count in bits 15:0 and a prescaler in bits 17:16 (0 = x1, 1 = x4, 2 = x16, 3 = x64). After the write that ends a block, the next request is delayed by count × prescale cycles. No gap is inserted when a block ends together with a per-trigger burst.
- R8: In triggered mode (bit 28 = 0), the channel waits until `trig_in[code]` is high, where code is control bits 27:24. Each trigger moves the words-per-trigger count. The run ends once the total count of words has been written, including when that happens at the end of a burst, with no further trigger. Repeat (bit 29) ignores the total count.
- R9: If control bit 15 is set, the source working address returns to the source register after every completed per-trigger burst. Bit 12 does the same for the destination. With a reload bit clear, that address keeps advancing from burst to burst.
- R10: With control bit 30 set, `irq` is high for exactly one cycle: the first cycle in which the enable bit reads 0 after a run. With bit 30 clear, `irq` stays low.
- R11: While `mem_req_ready` is low, a valid request holds its address, direction and data unchanged. Read data is taken from `mem_rsp_data` when `mem_rsp_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| trig_in | input | 16 | Trigger lines, one selected by the control code |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address of the request |
| mem_req_wdata | output | 32 | Write data |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| irq | output | 1 | Completion interrupt pulse |

## Verification
Several ends can fall on the same accepted write: the end of a block, the end of a per-trigger burst and the end of the total count. The block gap must then give way to the burst end, and the burst end to completion.

The bench provokes this with a fill run whose block size equals the words-per-trigger count and whose total is two bursts. It judges the result by measuring the cycles from trigger to first write, which must be exactly one. It also checks that the enable bit clears without a third trigger.

A sweep over block sizes, gap counts and prescalers measures the spacing between successive writes and compares it with the computed gap.

// File: rtl/wdma_pkg.sv
package wdma_pkg;
  localparam int WORD_W     = 32;
  localparam int STEP_BYTES = 4;

  // register indices; the order is fixed because software strides through it
  localparam logic [2:0] RI_SRC  = 3'd0;
  localparam logic [2:0] RI_DST  = 3'd1;
  localparam logic [2:0] RI_TOT  = 3'd2;
  localparam logic [2:0] RI_CNT  = 3'd3;
  localparam logic [2:0] RI_GAP  = 3'd4;
  localparam logic [2:0] RI_FILL = 3'd5;
  localparam logic [2:0] RI_CTL  = 3'd6;

  // control word bit positions
  localparam int CB_EN  = 31;
  localparam int CB_IRQ = 30;
  localparam int CB_REP = 29;
  localparam int CB_IMM = 28;
  localparam int CB_SRL = 15;
  localparam int CB_DRL = 12;

  typedef enum logic [1:0] {
    AM_INC  = 2'd0,
    AM_DEC  = 2'd1,
    AM_FIX  = 2'd2,
    AM_FILL = 2'd3
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RD,
    ST_RDW,
    ST_WR,
    ST_GAP
  } st_e;
endpackage

// File: rtl/wdma_regs.sv
module wdma_regs
  import wdma_pkg::*;
#(
  parameter int W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic         hw_clr,
  output logic [W-1:0] src_q,
  output logic [W-1:0] dst_q,
  output logic [W-1:0] tot_q,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] gap_q,
  output logic [W-1:0] fill_q,
  output logic [W-1:0] ctl_q,
  output logic [W-1:0] rdata
);
  logic lock;
  assign lock = ctl_q[CB_EN];

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= '0;
      dst_q  <= '0;
      tot_q  <= '0;
      cnt_q  <= '0;
      gap_q  <= '0;
      fill_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (we && !lock) begin
        case (addr)
          RI_SRC:  src_q  <= wdata;
          RI_DST:  dst_q  <= wdata;
          RI_TOT:  tot_q  <= wdata;
          RI_CNT:  cnt_q  <= wdata;
          RI_GAP:  gap_q  <= wdata;
          RI_FILL: fill_q <= wdata;
          RI_CTL:  ctl_q  <= wdata;
          default: ;
        endcase
      end
      if (hw_clr) ctl_q[CB_EN] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (addr)
        RI_SRC:  rdata <= src_q;
        RI_DST:  rdata <= dst_q;
        RI_TOT:  rdata <= tot_q;
        RI_CNT:  rdata <= cnt_q;
        RI_GAP:  rdata <= gap_q;
        RI_FILL: rdata <= fill_q;
        RI_CTL:  rdata <= ctl_q;
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/wdma_step.sv
module wdma_step
  import wdma_pkg::*;
#(
  parameter int W    = WORD_W,
  parameter int STEP = STEP_BYTES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         adv,
  input  logic [1:0]   mode,
  output logic [W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
    end else if (load) begin
      addr <= load_val;
    end else if (adv) begin
      case (mode)
        AM_INC:  addr <= addr + W'(STEP);
        AM_DEC:  addr <= addr - W'(STEP);
        default: addr <= addr;
      endcase
    end
  end
endmodule

// File: rtl/wdma_gap.sv
module wdma_gap #(
  parameter int IVW = 16,
  parameter int CW  = IVW + 6
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           arm,
  input  logic [IVW-1:0] ival,
  input  logic [1:0]     psel,
  output logic           len_zero,
  output logic           last
);
  logic [CW-1:0] len;
  logic [CW-1:0] cnt;

  // prescale of 1, 4, 16 or 64 is a left shift by 0, 2, 4 or 6
  assign len      = CW'(ival) << {psel, 1'b0};
  assign len_zero = (len == '0);
  assign last     = (cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (arm)         cnt <= len;
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/wdma_chan.sv
module wdma_chan
  import wdma_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int NTRIG = 16,
  parameter int IVW   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  input  logic [NTRIG-1:0] trig_in,
  output logic             mem_req_valid,
  output logic             mem_req_write,
  output logic [W-1:0]     mem_req_addr,
  output logic [W-1:0]     mem_req_wdata,
  input  logic             mem_req_ready,
  input  logic             mem_rsp_valid,
  input  logic [W-1:0]     mem_rsp_data,
  output logic             irq
);
  localparam int BW = 16;  // holds 2^15, the largest block

  logic [W-1:0] src_q, dst_q, tot_q, cnt_q, gap_q, fill_q, ctl_q;
  logic         done_c;

  wdma_regs #(.W(W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .hw_clr(done_c),
    .src_q(src_q), .dst_q(dst_q), .tot_q(tot_q), .cnt_q(cnt_q),
    .gap_q(gap_q), .fill_q(fill_q), .ctl_q(ctl_q), .rdata(reg_rdata)
  );

  // control fields
  logic [1:0] dmode, smode;
  logic [3:0] bexp, tcode;
  logic       imm, rep, irq_en, srl, drl, fill;
  assign dmode  = ctl_q[11:10];
  assign smode  = ctl_q[14:13];
  assign bexp   = ctl_q[19:16];
  assign tcode  = ctl_q[27:24];
  assign imm    = ctl_q[CB_IMM];
  assign rep    = ctl_q[CB_REP];
  assign irq_en = ctl_q[CB_IRQ];
  assign srl    = ctl_q[CB_SRL];
  assign drl    = ctl_q[CB_DRL];
  assign fill   = (smode == AM_FILL);

  logic [15:0] trig_pad;
  logic        trig_hit;
  assign trig_pad = 16'(trig_in);
  assign trig_hit = trig_pad[tcode];

  st_e          st;
  st_e          first_st;
  logic [W-1:0] tot_left, trg_left, rd_buf;
  logic [BW-1:0] blk_left, blk_size;
  logic         launch, wdone, last_trg, last_blk, last_tot, finish;
  logic         gap_arm, gap_zero, gap_last;
  logic [W-1:0] src_a, dst_a;

  assign first_st = fill ? ST_WR : ST_RD;
  assign blk_size = BW'(1) << bexp;
  assign launch   = (st == ST_IDLE) && ctl_q[CB_EN];
  assign wdone    = (st == ST_WR) && mem_req_ready;
  assign last_trg = (trg_left == W'(1));
  assign last_blk = (blk_left == BW'(1));
  assign last_tot = (tot_left == W'(1));
  assign finish   = !rep && (imm ? last_trg : last_tot);
  assign done_c   = wdone && finish;
  assign gap_arm  = wdone && !finish && !last_trg && last_blk;

  wdma_step #(.W(W)) u_src (
    .clk(clk), .rst(rst),
    .load(launch || (wdone && !finish && last_trg && srl)),
    .load_val(src_q), .adv(wdone && !fill), .mode(smode), .addr(src_a)
  );

  wdma_step #(.W(W)) u_dst (
    .clk(clk), .rst(rst),
    .load(launch || (wdone && !finish && last_trg && drl)),
    .load_val(dst_q), .adv(wdone), .mode(dmode), .addr(dst_a)
  );

  wdma_gap #(.IVW(IVW)) u_gap (
    .clk(clk), .rst(rst), .arm(gap_arm),
    .ival(gap_q[IVW-1:0]), .psel(gap_q[17:16]),
    .len_zero(gap_zero), .last(gap_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      tot_left <= '0;
      trg_left <= '0;
      blk_left <= '0;
      rd_buf   <= '0;
      irq      <= 1'b0;
    end else begin
      irq <= done_c && irq_en;
      case (st)
        ST_IDLE: if (launch) begin
          tot_left <= tot_q;
          trg_left <= cnt_q;
          blk_left <= blk_size;
          st       <= imm ? first_st : ST_WAIT;
        end
        ST_WAIT: if (trig_hit) st <= first_st;
        ST_RD:   if (mem_req_ready) st <= ST_RDW;
        ST_RDW:  if (mem_rsp_valid) begin
          rd_buf <= mem_rsp_data;
          st     <= ST_WR;
        end
        ST_WR: if (mem_req_ready) begin
          tot_left <= tot_left - W'(1);
          if (finish) begin
            st <= ST_IDLE;
          end else if (last_trg) begin
            trg_left <= cnt_q;
            blk_left <= blk_size;
            st       <= imm ? first_st : ST_WAIT;
          end else begin
            trg_left <= trg_left - W'(1);
            if (last_blk) begin
              blk_left <= blk_size;
              st       <= gap_zero ? first_st : ST_GAP;
            end else begin
              blk_left <= blk_left - BW'(1);
              st       <= first_st;
            end
          end
        end
        ST_GAP:  if (gap_last) st <= first_st;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st == ST_RD) || (st == ST_WR);
  assign mem_req_write = (st == ST_WR);
  assign mem_req_addr  = (st == ST_WR) ? dst_a : src_a;
  assign mem_req_wdata = fill ? fill_q : rd_buf;
endmodule

// File: rtl/wdma_chan_chk.sv
module wdma_chan_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         fill_mode,
  input logic         irq,
  input logic         req_valid,
  input logic         req_ready,
  input logic         req_write,
  input logic [W-1:0] req_addr,
  input logic [W-1:0] req_wdata
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata)); // R11

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R10

  AST_IRQ_AT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    irq |-> !en && $past(en)); // R10

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !en |-> !req_valid); // R3

  AST_FILL_WRITES_ONLY: assert property (@(posedge clk) disable iff (rst)
    en && fill_mode && req_valid |-> req_write); // R6
endmodule

bind wdma_chan wdma_chan_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .en(ctl_q[31]), .fill_mode(ctl_q[14:13] == 2'd3),
  .irq(irq), .req_valid(mem_req_valid), .req_ready(mem_req_ready),
  .req_write(mem_req_write), .req_addr(mem_req_addr), .req_wdata(mem_req_wdata)
);

// File: tb/wdma_chan_tb.sv
module wdma_chan_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] trig_in = '0;
  logic        mem_req_valid, mem_req_write, mem_req_ready;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        irq;

  always #2.5 clk = ~clk;  // 200 MHz

  wdma_chan u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_in(trig_in),
    .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .irq(irq)
  );

  // memory model and logs
  logic [31:0] mem [0:255];
  int          cyc = 0, wr_n = 0, rd_n = 0, irq_n = 0;
  int          wr_cyc [0:63];
  logic        stall_on = 1'b0;
  int          nchk = 0, nfail = 0;

  assign mem_req_ready = stall_on ? (cyc[1:0] == 2'd3) : 1'b1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_rsp_valid <= 1'b0;
    if (irq) irq_n <= irq_n + 1;
    if (mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        mem[mem_req_addr[9:2]] <= mem_req_wdata;
        if (wr_n < 64) wr_cyc[wr_n] <= cyc;
        wr_n <= wr_n + 1;
      end else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[9:2]];
        rd_n <= rd_n + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int k = 0; k < 20000; k++) begin
      rd_reg(3'd6, v);
      if (!v[31]) break;
    end
  endtask

  task automatic clr_logs();
    @(negedge clk);
    wr_n = 0; rd_n = 0; irq_n = 0;
  endtask

  task automatic pulse(input int line);
    @(negedge clk);
    trig_in = 16'(1) << line;
    @(negedge clk);
    trig_in = '0;
  endtask

  // control word: en irq rep imm code, n, srl sm drl dm
  function automatic logic [31:0] ctl(input bit en, input bit ie, input bit rp, input bit im,
      input logic [3:0] code, input logic [3:0] n, input bit srl, input logic [1:0] sm,
      input bit drl, input logic [1:0] dm);
    return {en, ie, rp, im, code, 4'd0, n, srl, sm, drl, dm, 10'd0};
  endfunction

  function automatic int off(input int mode, input int i);
    return (mode == 0) ? i : (mode == 1) ? -i : 0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int          tc;
    for (int k = 0; k < 256; k++) mem[k] = 32'hC0DE_0000 + k;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    for (int a = 0; a < 7; a++) begin
      rd_reg(3'(a), v);
      chk("R1 reg after reset", v, 32'h0);
    end
    chk("R1 valid idle", {31'd0, mem_req_valid}, 32'd0);
    chk("R1 irq idle", {31'd0, irq}, 32'd0);

    // R2: register map readback, channel left disabled
    for (int a = 0; a < 7; a++) wr_reg(3'(a), 32'h1234_0000 + 32'(a * 17));
    for (int a = 0; a < 7; a++) begin
      rd_reg(3'(a), v);
      chk("R2 readback", v, 32'h1234_0000 + 32'(a * 17));
    end

    // R4 R5 R6: copy sweep over source and destination modes
    for (int sm = 0; sm < 3; sm++) begin
      for (int dm = 0; dm < 3; dm++) begin
        for (int k = 150; k < 171; k++) mem[k] = 32'h0;
        clr_logs();
        wr_reg(3'd0, 32'(40 * 4));
        wr_reg(3'd1, 32'(160 * 4));
        wr_reg(3'd3, 32'd4);
        wr_reg(3'd4, 32'd0);
        wr_reg(3'd6, ctl(1, 0, 0, 1, 0, 0, 0, 2'(sm), 0, 2'(dm)));
        wait_idle();
        for (int i = 0; i < 4; i++) begin
          if (dm != 2 || i == 3)
            chk($sformatf("R5 R6 copy sm%0d dm%0d w%0d", sm, dm, i),
                mem[160 + off(dm, i)], 32'hC0DE_0000 + 32'(40 + off(sm, i)));
        end
        chk("R4 word count", 32'(wr_n), 32'd4);
        chk("R10 no irq when disabled", 32'(irq_n), 32'd0);
      end
    end

    // R6: fill mode issues no reads
    clr_logs();
    wr_reg(3'd1, 32'(100 * 4));
    wr_reg(3'd3, 32'd6);
    wr_reg(3'd5, 32'hA5A5_5A5A);
    wr_reg(3'd6, ctl(1, 0, 0, 1, 0, 0, 0, 2'd3, 0, 2'd0));
    wait_idle();
    for (int i = 0; i < 6; i++) chk("R6 fill word", mem[100 + i], 32'hA5A5_5A5A);
    chk("R6 no reads", 32'(rd_n), 32'd0);

    // R11: copy under a stalling ready
    for (int k = 0; k < 6; k++) mem[220 + k] = 32'h0;
    stall_on = 1'b1;
    clr_logs();
    wr_reg(3'd0, 32'(10 * 4));
    wr_reg(3'd1, 32'(220 * 4));
    wr_reg(3'd3, 32'd6);
    wr_reg(3'd6, ctl(1, 0, 0, 1, 0, 0, 0, 2'd0, 0, 2'd0));
    wait_idle();
    for (int i = 0; i < 6; i++) chk("R11 stalled copy", mem[220 + i], 32'hC0DE_0000 + 32'(10 + i));
    stall_on = 1'b0;

    // R7: block size x gap count x prescaler sweep, spacing of writes
    for (int n = 0; n < 3; n++) begin
      for (int iv = 0; iv < 3; iv++) begin
        for (int ps = 0; ps < 4; ps++) begin
          clr_logs();
          wr_reg(3'd1, 32'(100 * 4));
          wr_reg(3'd3, 32'd8);
          wr_reg(3'd4, {14'd0, 2'(ps), 16'(iv)});
          wr_reg(3'd6, ctl(1, 0, 0, 1, 0, 4'(n), 0, 2'd3, 0, 2'd0));
          wait_idle();
          for (int k = 1; k < 8; k++) begin
            int exp_sp;
            exp_sp = 1 + (((k % (1 << n)) == 0) ? (iv << (2 * ps)) : 0);
            chk($sformatf("R7 spacing n%0d iv%0d ps%0d k%0d", n, iv, ps, k),
                32'(wr_cyc[k] - wr_cyc[k-1]), 32'(exp_sp));
          end
        end
      end
    end

    // R8 R9 R10 R3: triggered copy, source reload, total 7, burst 3
    for (int k = 0; k < 8; k++) mem[200 + k] = 32'h0;
    clr_logs();
    wr_reg(3'd0, 32'(70 * 4));
    wr_reg(3'd1, 32'(200 * 4));
    wr_reg(3'd2, 32'd7);
    wr_reg(3'd3, 32'd3);
    wr_reg(3'd4, 32'd0);
    wr_reg(3'd6, ctl(1, 1, 0, 0, 4'd5, 0, 1, 2'd0, 0, 2'd0));
    repeat (10) @(negedge clk);
    chk("R8 waits for trigger", 32'(wr_n), 32'd0);
    wr_reg(3'd1, 32'hFFF0);
    rd_reg(3'd1, v);
    chk("R3 write ignored while busy", v, 32'(200 * 4));
    wr_reg(3'd6, 32'd0);
    rd_reg(3'd6, v);
    chk("R3 enable reads 1 while active", {31'd0, v[31]}, 32'd1);
    pulse(3);
    repeat (10) @(negedge clk);
    chk("R8 wrong line ignored", 32'(wr_n), 32'd0);
    pulse(5);
    repeat (30) @(negedge clk);
    chk("R8 first burst", 32'(wr_n), 32'd3);
    pulse(5);
    repeat (30) @(negedge clk);
    chk("R8 second burst", 32'(wr_n), 32'd6);
    rd_reg(3'd6, v);
    chk("R8 still enabled", {31'd0, v[31]}, 32'd1);
    pulse(5);
    wait_idle();
    chk("R8 total reached", 32'(wr_n), 32'd7);
    chk("R10 one irq pulse", 32'(irq_n), 32'd1);
    for (int i = 0; i < 7; i++)
      chk("R9 reload source", mem[200 + i], 32'hC0DE_0000 + 32'(70 + (i % 3)));

    // R7 R8: block end, burst end and total end coincide
    clr_logs();
    wr_reg(3'd1, 32'(100 * 4));
    wr_reg(3'd2, 32'd8);
    wr_reg(3'd3, 32'd4);
    wr_reg(3'd4, 32'd5);
    wr_reg(3'd6, ctl(1, 0, 0, 0, 4'd2, 4'd2, 0, 2'd3, 0, 2'd0));
    repeat (5) @(negedge clk);
    @(negedge clk);
    tc = cyc;
    trig_in = 16'd4;
    @(negedge clk);
    trig_in = '0;
    repeat (20) @(negedge clk);
    chk("R8 first burst latency", 32'(wr_cyc[0] - tc), 32'd1);
    @(negedge clk);
    tc = cyc;
    trig_in = 16'd4;
    @(negedge clk);
    trig_in = '0;
    repeat (20) @(negedge clk);
    chk("R7 no gap at burst end", 32'(wr_cyc[4] - tc), 32'd1);
    chk("R7 words in burst two", 32'(wr_cyc[7] - wr_cyc[4]), 32'd3);
    rd_reg(3'd6, v);
    chk("R8 ends at total without trigger", {31'd0, v[31]}, 32'd0);
    chk("R8 words moved", 32'(wr_n), 32'd8);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule